// File: doc/BRIEF.md
# Segmented Outbound Address Translation Unit

This block sits between a local bus and a serial fabric request builder. Each accepted request carries a local physical address and a read/write flag. The block turns it into a request descriptor: the translated target address, the destination device ID, the transaction type, the priority, and the window that produced them. Nine programmable windows are matched against the address. Window 0 acts as a catch-all default. The others are ranked by index.

Any window can be split into 1, 2 or 4 equal segments, and each segment into 1, 2 or 4 equal subsegments. Once a window is split, each region takes its destination ID from its own slot. Each segment also takes its own write type. The translated address then carries only the offset inside the region. Requests at the same offset in different regions therefore reach the same target offset on different devices. Several regions can also share one ID, which aliases them onto one device.

A single write port programs the windows, one 32-bit register at a time. The descriptor is registered and appears one clock after the request.

Top module: `seg_out_atu`

## Requirements
- R1: After a synchronous active-low reset, every window register is zero, so every window is disabled. The descriptor valid output is low until a request is accepted.
- R2: Windows 1 to 8 match when they are enabled and the address agrees with the window base on every bit at or above log2(size).
  - The enable is ATTR bit 31.
  - Size is 2^(code+1) bytes, where the code is ATTR bits [5:0].
  - The size is clamped to a minimum of 4 KB and a maximum of 4 GB.
  - The window is selected by cfg_win. The register is selected by cfg_sel: 0 = BASE, 1 = XLAT, 2 = ATTR, 3 = DEST, 4 = SEGT, 8 to 11 = SLOT.
- R3: When several of windows 1 to 8 match, the lowest-numbered one is reported.
- R4: If none of windows 1 to 8 matches and window 0 is enabled, window 0 serves the request, whatever the address. Otherwise the descriptor reports a miss: hit low, with window, address, destination, type and priority all zero.
- R5: The translated address is XLAT plus the request address modulo the region size, wrapped to 32 bits. The region is the whole window when it is not split, and one subsegment otherwise.
- R6: An unsplit window uses DEST bits [7:0] as the destination.
  - A split window uses the ID of slot i, where i = segment * subsegments + subsegment.
  - SLOT register 8+k holds the IDs of slots 4k to 4k+3, with slot 4k+j in bits [8j+7:8j].
- R7: The transaction type and priority come from ATTR.
  - A read takes ATTR bits [13:12].
  - A write to a window with more than one segment takes SEGT bits [2s+1:2s] of its segment s.
  - Any other write takes ATTR bits [17:16].
  - Priority is ATTR bits [21:20].
- R8: The descriptor valid output is high exactly in the cycle after a cycle with req_valid high.
- R9: A register write in the same cycle as a request does not affect that request. It takes effect from the next request onward.
- R10: log2(segments) is ATTR bits [7:6] and log2(subsegments) is ATTR bits [9:8]. The value 3 in either field behaves as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 4 | Window index of the write (9 and above ignored) |
| cfg_sel | input | 4 | Register select within the window |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request accepted this cycle |
| req_addr | input | 32 | Local physical address |
| req_write | input | 1 | 1 = write, 0 = read |
| dsc_valid | output | 1 | Descriptor valid |
| dsc_hit | output | 1 | A window served the request |
| dsc_win | output | 4 | Serving window index |
| dsc_addr | output | 32 | Translated target address |
| dsc_dest | output | 8 | Destination device ID |
| dsc_type | output | 2 | Transaction type code |
| dsc_prio | output | 2 | Transaction priority |

## Verification
The hardest case to reach from the ports is a fully split window whose slot index, segment index and region offset all depend on the size code at once. It is harder still when another window overlaps it and a register write lands in the same cycle as the request. Directed sequences build a 4 KB window of four 1 KB regions and a 64 KB window with clamped split fields. They then hit every region at the same offset and place a write beside a request. A random phase follows: it mixes register writes with addresses drawn near each programmed base, so overlaps, clamps and splits combine.

// File: rtl/otu_pkg.sv
// Package: shared constants and the decoded per-window configuration type.
// Assumes 32-bit local and target addresses and 8-bit device IDs.
package otu_pkg;
    localparam int ADDR_W       = 32;
    localparam int REG_W        = 32;
    localparam int DEST_W       = 8;
    localparam int TYPE_W       = 2;
    localparam int PRIO_W       = 2;
    localparam int NUM_WIN      = 9;
    localparam int WIN_IDX_W    = 4;
    localparam int SEL_W        = 4;
    localparam int LOG_FLD_W    = 2;
    localparam int SEG_LOG2_MAX = 2;
    localparam int SUB_LOG2_MAX = 2;
    localparam int SIZE_LOG2_MIN = 12;
    localparam int SEG_W        = SEG_LOG2_MAX;
    localparam int SLOT_W       = SEG_LOG2_MAX + SUB_LOG2_MAX;
    localparam int MAX_SEG      = 1 << SEG_LOG2_MAX;
    localparam int MAX_SLOT     = 1 << SLOT_W;
    localparam int IDS_PER_REG  = REG_W / DEST_W;
    localparam int SLOT_REGS    = MAX_SLOT / IDS_PER_REG;
    localparam int SZ_W         = $clog2(ADDR_W + 1);
    localparam int SPAN_W       = ADDR_W + 1;

    // Register selectors within one window
    localparam logic [SEL_W-1:0] SEL_BASE  = 4'd0;
    localparam logic [SEL_W-1:0] SEL_XLAT  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_ATTR  = 4'd2;
    localparam logic [SEL_W-1:0] SEL_DEST  = 4'd3;
    localparam logic [SEL_W-1:0] SEL_SEGT  = 4'd4;
    localparam logic [SEL_W-1:0] SEL_SLOT0 = 4'd8;

    typedef enum logic [TYPE_W-1:0] {
        XT_NREAD   = 2'd0,
        XT_NWRITE  = 2'd1,
        XT_NWRITER = 2'd2,
        XT_SWRITE  = 2'd3
    } xact_e;

    typedef struct packed {
        logic                                en;
        logic [ADDR_W-1:0]                   base;
        logic [ADDR_W-1:0]                   xaddr;
        logic [SZ_W-1:0]                     size_log2;
        logic [LOG_FLD_W-1:0]                seg_log2;
        logic [LOG_FLD_W-1:0]                sub_log2;
        logic [TYPE_W-1:0]                   rd_type;
        logic [TYPE_W-1:0]                   wr_type;
        logic [PRIO_W-1:0]                   prio;
        logic [DEST_W-1:0]                   dest;
        logic [MAX_SEG-1:0][TYPE_W-1:0]      seg_wtype;
        logic [MAX_SLOT-1:0][DEST_W-1:0]     slot_dest;
    } win_cfg_t;
endpackage

// File: rtl/otu_cfg_regs.sv
// Window register file: holds the raw registers of every window and decodes
// them into win_cfg_t. Writes land at the clock edge, so a request sampled in
// the same cycle still sees the old value. Writes to unknown selectors or to
// window indices at or above NUM_WIN are dropped.
module otu_cfg_regs
    import otu_pkg::*;
#(
    parameter int N_WIN = NUM_WIN
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [WIN_IDX_W-1:0]    cfg_win,
    input  logic [SEL_W-1:0]        cfg_sel,
    input  logic [REG_W-1:0]        cfg_wdata,
    output win_cfg_t [N_WIN-1:0]    cfg
);
    localparam int CODE_W = 6;

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        logic [REG_W-1:0]                  base_q, xlat_q, attr_q, segt_q;
        logic [DEST_W-1:0]                 dest_q;
        logic [SLOT_REGS-1:0][REG_W-1:0]   slot_q;
        logic                              sel_me;
        logic [SZ_W:0]                     raw_lg;

        assign sel_me = cfg_we && (cfg_win == WIN_IDX_W'(w));

        // Register update for this window
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                xlat_q <= '0;
                attr_q <= '0;
                segt_q <= '0;
                dest_q <= '0;
                slot_q <= '0;
            end else if (sel_me) begin
                case (cfg_sel)
                    SEL_BASE: base_q <= cfg_wdata;
                    SEL_XLAT: xlat_q <= cfg_wdata;
                    SEL_ATTR: attr_q <= cfg_wdata;
                    SEL_DEST: dest_q <= cfg_wdata[DEST_W-1:0];
                    SEL_SEGT: segt_q <= cfg_wdata;
                    default: begin
                        for (int k = 0; k < SLOT_REGS; k++) begin
                            if (cfg_sel == SEL_SLOT0 + SEL_W'(k)) slot_q[k] <= cfg_wdata;
                        end
                    end
                endcase
            end
        end

        assign raw_lg = (SZ_W+1)'(attr_q[CODE_W-1:0]) + (SZ_W+1)'(1);

        // Decode raw registers into the configuration record
        always_comb begin
            cfg[w].en    = attr_q[REG_W-1];
            cfg[w].base  = base_q[ADDR_W-1:0];
            cfg[w].xaddr = xlat_q[ADDR_W-1:0];
            if (raw_lg < (SZ_W+1)'(SIZE_LOG2_MIN))
                cfg[w].size_log2 = SZ_W'(SIZE_LOG2_MIN);
            else if (raw_lg > (SZ_W+1)'(ADDR_W))
                cfg[w].size_log2 = SZ_W'(ADDR_W);
            else
                cfg[w].size_log2 = raw_lg[SZ_W-1:0];
            cfg[w].seg_log2 = (attr_q[7:6] > LOG_FLD_W'(SEG_LOG2_MAX)) ?
                              LOG_FLD_W'(SEG_LOG2_MAX) : attr_q[7:6];
            cfg[w].sub_log2 = (attr_q[9:8] > LOG_FLD_W'(SUB_LOG2_MAX)) ?
                              LOG_FLD_W'(SUB_LOG2_MAX) : attr_q[9:8];
            cfg[w].rd_type = attr_q[13:12];
            cfg[w].wr_type = attr_q[17:16];
            cfg[w].prio    = attr_q[21:20];
            cfg[w].dest    = dest_q;
            for (int s = 0; s < MAX_SEG; s++)
                cfg[w].seg_wtype[s] = segt_q[s*TYPE_W +: TYPE_W];
            for (int i = 0; i < MAX_SLOT; i++)
                cfg[w].slot_dest[i] = slot_q[i / IDS_PER_REG][(i % IDS_PER_REG)*DEST_W +: DEST_W];
        end
    end
endmodule

// File: rtl/otu_win_match.sv
// Window matcher: flags each window whose enabled range covers the address
// and picks the winner (lowest of 1..N-1, else window 0 as default).
// Assumes window 0 is a catch-all when enabled.
module otu_win_match
    import otu_pkg::*;
#(
    parameter int N_WIN = NUM_WIN
) (
    input  win_cfg_t [N_WIN-1:0]    cfg,
    input  logic [ADDR_W-1:0]       addr,
    output logic [N_WIN-1:0]        hit_vec,
    output logic                    any_hit,
    output logic [WIN_IDX_W-1:0]    win_idx
);
    for (genvar w = 0; w < N_WIN; w++) begin : g_cmp
        if (w == 0) begin : g_dflt
            assign hit_vec[w] = cfg[w].en;
        end else begin : g_rng
            logic [ADDR_W-1:0] diff;
            assign diff       = addr ^ cfg[w].base;
            assign hit_vec[w] = cfg[w].en && ((diff >> cfg[w].size_log2) == '0);
        end
    end

    // Priority pick: scan downward so the lowest ranged window wins
    always_comb begin
        any_hit = hit_vec[0];
        win_idx = '0;
        for (int w = N_WIN - 1; w >= 1; w--) begin
            if (hit_vec[w]) begin
                any_hit = 1'b1;
                win_idx = WIN_IDX_W'(w);
            end
        end
    end
endmodule

// File: rtl/otu_xlate.sv
// Translation datapath for one selected window: splits the window offset into
// a slot index and an in-region offset, then forms address, ID and type.
// Assumes size_log2 >= seg_log2 + sub_log2 (guaranteed by the 4 KB floor).
module otu_xlate
    import otu_pkg::*;
(
    input  win_cfg_t               cfg,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   is_write,
    output logic [ADDR_W-1:0]      t_addr,
    output logic [DEST_W-1:0]      t_dest,
    output logic [TYPE_W-1:0]      t_type,
    output logic [PRIO_W-1:0]      t_prio
);
    logic [SPAN_W-1:0]      win_span, sub_span;
    logic [ADDR_W-1:0]      win_mask, sub_mask, win_off;
    logic [LOG_FLD_W:0]     part_lg;
    logic [SZ_W-1:0]        sub_lg;
    logic [SLOT_W-1:0]      slot_idx;
    logic [SEG_W-1:0]       seg_idx;

    // Region geometry from the size and split fields
    always_comb begin
        part_lg  = (LOG_FLD_W+1)'(cfg.seg_log2) + (LOG_FLD_W+1)'(cfg.sub_log2);
        sub_lg   = cfg.size_log2 - SZ_W'(part_lg);
        win_span = SPAN_W'(1) << cfg.size_log2;
        sub_span = SPAN_W'(1) << sub_lg;
        win_mask = ADDR_W'(win_span - SPAN_W'(1));
        sub_mask = ADDR_W'(sub_span - SPAN_W'(1));
        win_off  = addr & win_mask;
        slot_idx = SLOT_W'(win_off >> sub_lg);
        seg_idx  = SEG_W'(slot_idx >> cfg.sub_log2);
    end

    // Descriptor fields for the selected window
    always_comb begin
        t_addr = cfg.xaddr + (addr & sub_mask);
        t_dest = (part_lg == '0) ? cfg.dest : cfg.slot_dest[slot_idx];
        if (!is_write)
            t_type = cfg.rd_type;
        else if (cfg.seg_log2 != '0)
            t_type = cfg.seg_wtype[seg_idx];
        else
            t_type = cfg.wr_type;
        t_prio = cfg.prio;
    end
endmodule

// File: rtl/seg_out_atu.sv
// Top: outbound translation unit. Registers window configuration, matches
// each request against the windows, translates through the winner and
// registers the descriptor one clock after the request.
// Assumes requests are single-cycle strobes with no back-pressure.
module seg_out_atu
    import otu_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [WIN_IDX_W-1:0]    cfg_win,
    input  logic [SEL_W-1:0]        cfg_sel,
    input  logic [REG_W-1:0]        cfg_wdata,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_write,
    output logic                    dsc_valid,
    output logic                    dsc_hit,
    output logic [WIN_IDX_W-1:0]    dsc_win,
    output logic [ADDR_W-1:0]       dsc_addr,
    output logic [DEST_W-1:0]       dsc_dest,
    output logic [TYPE_W-1:0]       dsc_type,
    output logic [PRIO_W-1:0]       dsc_prio
);
    win_cfg_t [NUM_WIN-1:0]  cfg;
    win_cfg_t                sel_cfg;
    logic [NUM_WIN-1:0]      hit_vec;
    logic                    any_hit;
    logic [WIN_IDX_W-1:0]    win_idx;
    logic [ADDR_W-1:0]       t_addr;
    logic [DEST_W-1:0]       t_dest;
    logic [TYPE_W-1:0]       t_type;
    logic [PRIO_W-1:0]       t_prio;

    otu_cfg_regs #(.N_WIN(NUM_WIN)) i_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg(cfg)
    );

    otu_win_match #(.N_WIN(NUM_WIN)) i_match (
        .cfg(cfg), .addr(req_addr), .hit_vec(hit_vec),
        .any_hit(any_hit), .win_idx(win_idx)
    );

    // Route the winning window's configuration to the datapath
    always_comb begin
        sel_cfg = cfg[0];
        for (int w = 1; w < NUM_WIN; w++)
            if (win_idx == WIN_IDX_W'(w)) sel_cfg = cfg[w];
    end

    otu_xlate i_xlate (
        .cfg(sel_cfg), .addr(req_addr), .is_write(req_write),
        .t_addr(t_addr), .t_dest(t_dest), .t_type(t_type), .t_prio(t_prio)
    );

    // Descriptor register: one cycle after the request, zeros on a miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsc_valid <= 1'b0;
            dsc_hit   <= 1'b0;
            dsc_win   <= '0;
            dsc_addr  <= '0;
            dsc_dest  <= '0;
            dsc_type  <= '0;
            dsc_prio  <= '0;
        end else begin
            dsc_valid <= req_valid;
            if (req_valid && any_hit) begin
                dsc_hit  <= 1'b1;
                dsc_win  <= win_idx;
                dsc_addr <= t_addr;
                dsc_dest <= t_dest;
                dsc_type <= t_type;
                dsc_prio <= t_prio;
            end else begin
                dsc_hit  <= 1'b0;
                dsc_win  <= '0;
                dsc_addr <= '0;
                dsc_dest <= '0;
                dsc_type <= '0;
                dsc_prio <= '0;
            end
        end
    end
endmodule

// File: rtl/otu_chk.sv
// Checker for seg_out_atu: relates the registered descriptor to the match
// flags of the previous cycle and to the request strobe.
module otu_chk
    import otu_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [NUM_WIN-1:0]    hit_vec,
    input logic                  dsc_valid,
    input logic                  dsc_hit,
    input logic [WIN_IDX_W-1:0]  dsc_win,
    input logic [ADDR_W-1:0]     dsc_addr,
    input logic [DEST_W-1:0]     dsc_dest
);
    logic [NUM_WIN-1:0] hv_prev;
    logic [NUM_WIN-1:0] below_mask;

    // Match flags as seen by the request now being reported
    always_ff @(posedge clk) begin
        if (!rst_n) hv_prev <= '0;
        else        hv_prev <= hit_vec;
    end

    assign below_mask = NUM_WIN'((32'd1 << dsc_win) - 32'd1) & ~NUM_WIN'(1);

    AST_DSC_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> dsc_valid); // R8
    AST_NO_SPURIOUS_DSC: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !dsc_valid); // R8
    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_valid && !dsc_hit) |-> (dsc_addr == '0 && dsc_dest == '0 && dsc_win == '0)); // R4
    AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_valid && dsc_hit) |-> (dsc_win < WIN_IDX_W'(NUM_WIN))); // R3
    AST_WINNER_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_valid && dsc_hit && dsc_win < WIN_IDX_W'(NUM_WIN)) |-> hv_prev[dsc_win]); // R2
    AST_NO_LOWER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_valid && dsc_hit && dsc_win < WIN_IDX_W'(NUM_WIN)) |-> ((hv_prev & below_mask) == '0)); // R3
    AST_DEFAULT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_valid && dsc_hit && dsc_win == '0) |-> (hv_prev[NUM_WIN-1:1] == '0)); // R4
endmodule

bind seg_out_atu otu_chk i_otu_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hit_vec(hit_vec),
    .dsc_valid(dsc_valid), .dsc_hit(dsc_hit), .dsc_win(dsc_win),
    .dsc_addr(dsc_addr), .dsc_dest(dsc_dest)
);

// File: tb/test_seg_out_atu.sv
// Bench: behavioural model of the window registers and translation rules,
// compared with the descriptor on every clock.
module test_seg_out_atu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_win = '0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        dsc_valid, dsc_hit;
    logic [3:0]  dsc_win;
    logic [31:0] dsc_addr;
    logic [7:0]  dsc_dest;
    logic [1:0]  dsc_type, dsc_prio;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10ns clk = ~clk;

    seg_out_atu i_seg_out_atu (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .dsc_valid(dsc_valid),
        .dsc_hit(dsc_hit), .dsc_win(dsc_win), .dsc_addr(dsc_addr),
        .dsc_dest(dsc_dest), .dsc_type(dsc_type), .dsc_prio(dsc_prio)
    );

    // Model state
    logic [31:0] m_base [9], m_xlat [9], m_attr [9], m_segt [9];
    logic [7:0]  m_dest [9];
    logic [31:0] m_slot [9][4];

    // Pending expectation for the next compare
    bit          p_valid, e_hit;
    int          e_win;
    logic [31:0] e_addr;
    logic [7:0]  e_dest;
    logic [1:0]  e_type, e_prio;
    string       p_tag = "R1";

    task automatic model_reset();
        for (int k = 0; k < 9; k++) begin
            m_base[k] = 0; m_xlat[k] = 0; m_attr[k] = 0; m_segt[k] = 0; m_dest[k] = 0;
            for (int j = 0; j < 4; j++) m_slot[k][j] = 0;
        end
        p_valid = 0;
    endtask

    function automatic longint unsigned win_size(int k);
        int lg = int'(m_attr[k][5:0]) + 1;
        if (lg < 12) lg = 12;
        if (lg > 32) lg = 32;
        return 64'd1 << lg;
    endfunction

    task automatic predict(input logic [31:0] a, input logic w);
        int sel = -1;
        longint unsigned la = a;
        e_hit = 0; e_win = 0; e_addr = 0; e_dest = 0; e_type = 0; e_prio = 0;
        for (int k = 1; k < 9; k++) begin
            longint unsigned sz = win_size(k);
            longint unsigned lb = m_base[k];
            if (sel < 0 && m_attr[k][31] && (la / sz) == (lb / sz)) sel = k;
        end
        if (sel < 0 && m_attr[0][31]) sel = 0;
        if (sel >= 0) begin
            longint unsigned sz = win_size(sel);
            int sg = int'(m_attr[sel][7:6]);
            int sb = int'(m_attr[sel][9:8]);
            longint unsigned sub, off, idx;
            if (sg > 2) sg = 2;
            if (sb > 2) sb = 2;
            sub = sz / (64'd1 << (sg + sb));
            off = la % sz;
            idx = off / sub;
            e_hit = 1;
            e_win = sel;
            e_addr = 32'(longint'(m_xlat[sel]) + longint'(off % sub));
            if (sg + sb == 0) e_dest = m_dest[sel];
            else e_dest = 8'(m_slot[sel][idx / 4] >> (8 * (idx % 4)));
            if (!w) e_type = m_attr[sel][13:12];
            else if (sg != 0) e_type = 2'(m_segt[sel] >> (2 * (idx / (64'd1 << sb))));
            else e_type = m_attr[sel][17:16];
            e_prio = m_attr[sel][21:20];
        end
    endtask

    task automatic model_write(input logic [3:0] wn, input logic [3:0] sl, input logic [31:0] d);
        if (wn < 9) begin
            if (sl == 0) m_base[wn] = d;
            else if (sl == 1) m_xlat[wn] = d;
            else if (sl == 2) m_attr[wn] = d;
            else if (sl == 3) m_dest[wn] = d[7:0];
            else if (sl == 4) m_segt[wn] = d;
            else if (sl >= 8 && sl < 12) m_slot[wn][sl - 8] = d;
        end
    endtask

    task automatic compare();
        checks++;
        if (dsc_valid !== p_valid) begin
            errors++;
            $display("FAIL %s valid: actual %0b expected %0b", p_tag, dsc_valid, p_valid);
        end else if (p_valid) begin
            if (dsc_hit !== e_hit || dsc_win !== 4'(e_win) || dsc_addr !== e_addr ||
                dsc_dest !== e_dest || dsc_type !== e_type || dsc_prio !== e_prio) begin
                errors++;
                $display("FAIL %s descriptor: actual hit=%0b win=%0d addr=%h dest=%h type=%0d prio=%0d expected hit=%0b win=%0d addr=%h dest=%h type=%0d prio=%0d",
                         p_tag, dsc_hit, dsc_win, dsc_addr, dsc_dest, dsc_type, dsc_prio,
                         e_hit, e_win, e_addr, e_dest, e_type, e_prio);
            end
        end
    endtask

    // One clock: compare the previous expectation, then drive this cycle
    task automatic tick(input bit wv, input logic [3:0] wn, input logic [3:0] sl,
                        input logic [31:0] d, input bit rv, input logic [31:0] a,
                        input bit w, input string tag);
        @(negedge clk);
        compare();
        cfg_we = wv; cfg_win = wn; cfg_sel = sl; cfg_wdata = d;
        req_valid = rv; req_addr = a; req_write = w;
        p_valid = rv;
        p_tag = tag;
        if (rv) predict(a, w);
        if (wv) model_write(wn, sl, d);
    endtask

    task automatic wr(input int wn, input int sl, input logic [31:0] d);
        tick(1, 4'(wn), 4'(sl), d, 0, 0, 0, "R8");
    endtask

    task automatic rq(input logic [31:0] a, input bit w, input string tag);
        tick(0, 0, 0, 0, 1, a, w, tag);
    endtask

    // Watchdog
    initial begin
        #(20ns * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (dsc_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset valid: actual %0b expected 0", dsc_valid);
        end
        rst_n = 1'b1;
        tick(0, 0, 0, 0, 0, 0, 0, "R1");
        rq(32'h0000_1234, 0, "R1");          // all windows disabled: miss
        tick(0, 0, 0, 0, 0, 0, 0, "R8");

        // R4: default window
        wr(0, 1, 32'h8000_0000);
        wr(0, 2, 32'h8000_0000 | 15 | (1 << 16) | (1 << 20));
        wr(0, 3, 32'h22);
        rq(32'hABCD_1234, 1, "R4");
        rq(32'h0000_0010, 0, "R4");

        // R2 / R5: ranged window 3, 64 KB
        wr(3, 0, 32'h1000_0000);
        wr(3, 1, 32'h2000_0000);
        wr(3, 3, 32'h33);
        wr(3, 2, 32'h8000_0000 | 15 | (3 << 16) | (2 << 20) | (2 << 12));
        rq(32'h1000_FFFC, 1, "R2");
        rq(32'h1000_FFFC, 0, "R5");
        rq(32'h1001_0000, 1, "R2");          // just past the end: default

        // R3: overlap of windows 2 and 3
        wr(2, 0, 32'h1000_0000);
        wr(2, 3, 32'h44);
        wr(2, 2, 32'h8000_0000 | 19);
        rq(32'h1000_0010, 1, "R3");
        rq(32'h100F_0000, 1, "R3");
        wr(2, 2, 32'h0000_0013);             // disabled
        rq(32'h1000_0010, 1, "R3");

        // R6 / R7: 4 KB window, 2 segments of 2 subsegments
        wr(1, 0, 32'h4000_0000);
        wr(1, 1, 32'h0000_5000);
        wr(1, 8, 32'h0908_0504);
        wr(1, 4, 32'h0000_000D);             // seg0 type 1, seg1 type 3
        wr(1, 2, 32'h8000_0000 | 11 | (1 << 6) | (1 << 8) | (3 << 20) | (2 << 12));
        rq(32'h4000_0000, 1, "R6");
        rq(32'h4000_0400, 1, "R6");
        rq(32'h4000_0800, 1, "R7");
        rq(32'h4000_0C10, 1, "R7");
        rq(32'h4000_0C00, 0, "R7");
        tick(0, 0, 0, 0, 0, 0, 0, "R8");

        // R10: split fields of 3 behave as 2 (16 slots of 4 KB)
        wr(4, 0, 32'h5000_0000);
        wr(4, 1, 32'h7000_0000);
        for (int k = 0; k < 4; k++)
            wr(4, 8 + k, {8'(8'h13 + 4*k), 8'(8'h12 + 4*k), 8'(8'h11 + 4*k), 8'(8'h10 + 4*k)});
        wr(4, 4, 32'h0000_00E4);
        wr(4, 2, 32'h8000_0000 | 15 | (3 << 6) | (3 << 8));
        rq(32'h5000_F123, 1, "R10");
        rq(32'h5000_4FFF, 1, "R10");
        rq(32'h5000_9000, 0, "R10");

        // R2: size code below the floor clamps to 4 KB
        wr(5, 0, 32'h6000_0000);
        wr(5, 3, 32'h55);
        wr(5, 2, 32'h8000_0000 | 3);
        rq(32'h6000_0FFF, 1, "R2");
        rq(32'h6000_1000, 1, "R2");

        // R9: write in the same cycle as a request
        tick(1, 5, 2, 32'h0000_0003, 1, 32'h6000_0000, 1, "R9");
        rq(32'h6000_0000, 1, "R9");
        tick(1, 0, 3, 32'h77, 1, 32'h0000_0100, 0, "R9");
        rq(32'h0000_0100, 0, "R9");

        // R4: default disabled gives a miss
        wr(0, 2, 32'h0);
        rq(32'h0000_0100, 1, "R4");

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            bit wv = ($urandom_range(0, 3) == 0);
            int wn = $urandom_range(0, 9);
            int sl = $urandom_range(0, 11);
            logic [31:0] d = $urandom();
            bit rv = ($urandom_range(0, 3) != 0);
            int bw = $urandom_range(0, 8);
            logic [31:0] a = m_base[bw] + ($urandom() & 32'h0001_FFFF);
            if (sl == 2) d = (d & 32'h8033_33FF) | ($urandom_range(0, 1) << 31);
            if (sl == 0 && $urandom_range(0, 1) == 0) d = d & 32'hFFFF_0000;
            if ($urandom_range(0, 7) == 0) a = $urandom();
            tick(wv, 4'(wn), 4'(sl), d, rv, a, 1'($urandom_range(0, 1)), "R5");
        end
        tick(0, 0, 0, 0, 0, 0, 0, "R8");
        tick(0, 0, 0, 0, 0, 0, 0, "R8");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule